// File: doc/BRIEF.md
# Cache Port Occupancy Tracker

This block keeps track of how long the data port and the fill port of a cache stay busy. Each access that the cache completes is presented once, with its outcome, its size in bytes and whether it caused a dirty line to be written back. From these the block works out how many port cycles the access takes and adds them to the data-port occupancy count. Each line fill returning from the next memory level adds one line's worth of cycles to the fill-port occupancy count. Both counts drain by one every clock.

A scheduler upstream reads the two free flags to decide whether a new access or fill may start. Three free-running counters give the number of cycles observed and, for each port, how many of them the port was occupied, so that a utilization ratio can be computed outside.

Top module: `port_occupancy_tracker`

## Requirements
- R1: An access with outcome code 0 (hit) charges the data port ceil(bytes / PORT_BYTES) cycles, with sizes above LINE_BYTES treated as LINE_BYTES; a size of 0 charges nothing.
- R2: An access with outcome code 1 (hit on a line still being filled) or code 2 (miss) charges LINE_BYTES / PORT_BYTES cycles when its writeback flag is set and nothing when it is clear.
- R3: An access with outcome code 3 (rejected for lack of resources) charges nothing, whatever its writeback flag.
- R4: A fill strobe charges the fill port LINE_BYTES / PORT_BYTES cycles.
- R5: Each clock the new occupancy of a port is its old occupancy plus the charge taken that clock, minus one, never below zero.
- R6: Each free flag is high exactly when the occupancy of its port, as updated at the last clock, is zero; after reset both flags are high.
- R7: The cycle counter rises by one each clock after reset; each port's busy counter rises by one on each clock at which that port's free flag was low before the edge.
- R8: An occupancy count that would exceed 2^OCC_W - 1 holds at 2^OCC_W - 1.
- R9: While acc_valid is low, the outcome, size and writeback inputs charge nothing.
- R10: Reset sets all counters and occupancies to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access completes this cycle |
| acc_outcome | input | 2 | Outcome code of the access (0 hit, 1 hit pending, 2 miss, 3 rejected) |
| acc_bytes | input | $clog2(LINE_BYTES)+1 | Request size in bytes |
| acc_wb | input | 1 | The access issued a writeback of a dirty line |
| fill_strobe | input | 1 | A line fill arrives this cycle |
| data_port_free | output | 1 | Data port occupancy is zero |
| fill_port_free | output | 1 | Fill port occupancy is zero |
| cycles_seen | output | STAT_W | Clocks counted since reset |
| data_busy_cycles | output | STAT_W | Clocks with the data port occupied |
| fill_busy_cycles | output | STAT_W | Clocks with the fill port occupied |

## Verification
The bench builds the block with a 64-byte line, a 16-byte port and a 5-bit occupancy count, so a line costs four cycles and the saturation limit of 31 is reached within a dozen back-to-back charges. That small setting lets it sweep every outcome code against every request size from 0 to 80 bytes, including the rounding steps and the clamp above one line, with and without writeback, and then drain each charge to zero. Overlapping charges with fills, idle accesses and a long saturating burst cover the same-cycle add-and-drain rule and the ceiling.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    OUT_HIT      = 2'd0,
    OUT_HIT_PEND = 2'd1,
    OUT_MISS     = 2'd2,
    OUT_REJECT   = 2'd3
  } outcome_e;
endpackage

// File: rtl/occ_charge_calc.sv
module occ_charge_calc #(
  parameter int LINE_BYTES = 128,
  parameter int PORT_BYTES = 32,
  parameter int SIZE_W     = $clog2(LINE_BYTES) + 1,
  parameter int CH_W       = $clog2(LINE_BYTES / PORT_BYTES) + 1
) (
  input  logic              acc_valid,
  input  logic [1:0]        acc_outcome,
  input  logic [SIZE_W-1:0] acc_bytes,
  input  logic              acc_wb,
  output logic [CH_W-1:0]   data_charge,
  output logic [CH_W-1:0]   line_charge
);
  import occ_pkg::*;
  localparam int PLOG     = $clog2(PORT_BYTES);
  localparam int LINE_CYC = LINE_BYTES / PORT_BYTES;

  outcome_e          kind;
  logic [SIZE_W:0]   clamped;
  logic [SIZE_W:0]   rounded;

  assign kind        = outcome_e'(acc_outcome);
  assign line_charge = CH_W'(LINE_CYC);

  always_comb begin
    if ({1'b0, acc_bytes} > (SIZE_W+1)'(LINE_BYTES))
      clamped = (SIZE_W+1)'(LINE_BYTES);
    else
      clamped = {1'b0, acc_bytes};
    rounded = (clamped + (SIZE_W+1)'(PORT_BYTES - 1)) >> PLOG;
  end

  always_comb begin
    data_charge = '0;
    if (acc_valid) begin
      case (kind)
        OUT_HIT:               data_charge = CH_W'(rounded);
        OUT_HIT_PEND, OUT_MISS: data_charge = acc_wb ? line_charge : '0;
        default:               data_charge = '0;
      endcase
    end
  end
endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int OCC_W = 6,
  parameter int CH_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_W-1:0] charge,
  output logic            port_free
);
  localparam logic [OCC_W:0] MAX_OCC = {1'b0, {OCC_W{1'b1}}};

  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] occ_d;
  logic [OCC_W:0]   sum;

  always_comb begin
    sum = {1'b0, occ_q} + (OCC_W+1)'(charge);
    if (sum == '0)
      occ_d = '0;
    else if ((sum - 1'b1) > MAX_OCC)
      occ_d = MAX_OCC[OCC_W-1:0];
    else
      occ_d = OCC_W'(sum - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q     <= '0;
      port_free <= 1'b1;
    end else begin
      occ_q     <= occ_d;
      port_free <= (occ_d == '0);
    end
  end
endmodule

// File: rtl/occ_util_stats.sv
module occ_util_stats #(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_busy,
  input  logic              fill_busy,
  output logic [STAT_W-1:0] cycles_seen,
  output logic [STAT_W-1:0] data_busy_cycles,
  output logic [STAT_W-1:0] fill_busy_cycles
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cycles_seen      <= '0;
      data_busy_cycles <= '0;
      fill_busy_cycles <= '0;
    end else begin
      cycles_seen <= cycles_seen + 1'b1;
      if (data_busy) data_busy_cycles <= data_busy_cycles + 1'b1;
      if (fill_busy) fill_busy_cycles <= fill_busy_cycles + 1'b1;
    end
  end
endmodule

// File: rtl/port_occupancy_tracker.sv
module port_occupancy_tracker #(
  parameter int LINE_BYTES = 128,
  parameter int PORT_BYTES = 32,
  parameter int OCC_W      = 6,
  parameter int STAT_W     = 32,
  parameter int SIZE_W     = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [1:0]        acc_outcome,
  input  logic [SIZE_W-1:0] acc_bytes,
  input  logic              acc_wb,
  input  logic              fill_strobe,
  output logic              data_port_free,
  output logic              fill_port_free,
  output logic [STAT_W-1:0] cycles_seen,
  output logic [STAT_W-1:0] data_busy_cycles,
  output logic [STAT_W-1:0] fill_busy_cycles
);
  localparam int CH_W = $clog2(LINE_BYTES / PORT_BYTES) + 1;

  logic [CH_W-1:0] data_charge;
  logic [CH_W-1:0] line_charge;
  logic [CH_W-1:0] charge [2];
  logic            free_v [2];

  occ_charge_calc #(
    .LINE_BYTES(LINE_BYTES), .PORT_BYTES(PORT_BYTES),
    .SIZE_W(SIZE_W), .CH_W(CH_W)
  ) u_calc (
    .acc_valid  (acc_valid),
    .acc_outcome(acc_outcome),
    .acc_bytes  (acc_bytes),
    .acc_wb     (acc_wb),
    .data_charge(data_charge),
    .line_charge(line_charge)
  );

  assign charge[0] = data_charge;
  assign charge[1] = fill_strobe ? line_charge : '0;

  for (genvar p = 0; p < 2; p++) begin : g_port
    occ_counter #(.OCC_W(OCC_W), .CH_W(CH_W)) u_occ (
      .clk      (clk),
      .rst      (rst),
      .charge   (charge[p]),
      .port_free(free_v[p])
    );
  end

  assign data_port_free = free_v[0];
  assign fill_port_free = free_v[1];

  occ_util_stats #(.STAT_W(STAT_W)) u_stats (
    .clk             (clk),
    .rst             (rst),
    .data_busy       (!data_port_free),
    .fill_busy       (!fill_port_free),
    .cycles_seen     (cycles_seen),
    .data_busy_cycles(data_busy_cycles),
    .fill_busy_cycles(fill_busy_cycles)
  );
endmodule

// File: rtl/port_occupancy_checker.sv
module port_occupancy_checker #(
  parameter int LINE_BYTES = 128,
  parameter int PORT_BYTES = 32,
  parameter int STAT_W     = 32,
  parameter int SIZE_W     = $clog2(LINE_BYTES) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [1:0]        acc_outcome,
  input logic [SIZE_W-1:0] acc_bytes,
  input logic              acc_wb,
  input logic              fill_strobe,
  input logic              data_port_free,
  input logic              fill_port_free,
  input logic [STAT_W-1:0] cycles_seen,
  input logic [STAT_W-1:0] data_busy_cycles,
  input logic [STAT_W-1:0] fill_busy_cycles
);
  localparam int LINE_CYC = LINE_BYTES / PORT_BYTES;
  localparam logic MULTI = (LINE_CYC > 1);

  p_reject_no_charge_r3: assert property (@(posedge clk) disable iff (rst)
    (data_port_free && acc_valid && acc_outcome == 2'd3) |=> data_port_free);

  p_idle_no_charge_r9: assert property (@(posedge clk) disable iff (rst)
    (data_port_free && !acc_valid) |=> data_port_free);

  p_hit_charges_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_outcome == 2'd0 && acc_bytes > SIZE_W'(PORT_BYTES)) |=> !data_port_free);

  p_fill_charges_r4: assert property (@(posedge clk) disable iff (rst)
    (MULTI && fill_strobe) |=> !fill_port_free);

  p_fill_drains_r5: assert property (@(posedge clk) disable iff (rst)
    (fill_port_free && !fill_strobe) |=> fill_port_free);

  p_cycle_step_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cycles_seen == $past(cycles_seen) + 1'b1);

  p_data_busy_step_r7: assert property (@(posedge clk) disable iff (rst)
    !data_port_free |=> data_busy_cycles == $past(data_busy_cycles) + 1'b1);

  p_fill_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    fill_port_free |=> $stable(fill_busy_cycles));
endmodule

bind port_occupancy_tracker port_occupancy_checker #(
  .LINE_BYTES(LINE_BYTES), .PORT_BYTES(PORT_BYTES),
  .STAT_W(STAT_W), .SIZE_W(SIZE_W)
) u_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_outcome(acc_outcome),
  .acc_bytes(acc_bytes), .acc_wb(acc_wb), .fill_strobe(fill_strobe),
  .data_port_free(data_port_free), .fill_port_free(fill_port_free),
  .cycles_seen(cycles_seen), .data_busy_cycles(data_busy_cycles),
  .fill_busy_cycles(fill_busy_cycles)
);

// File: tb/test_port_occupancy_tracker.sv
module test_port_occupancy_tracker;
  localparam int LINE_BYTES = 64;
  localparam int PORT_BYTES = 16;
  localparam int OCC_W      = 5;
  localparam int STAT_W     = 16;
  localparam int SIZE_W     = $clog2(LINE_BYTES) + 1;
  localparam int LINE_CYC   = LINE_BYTES / PORT_BYTES;
  localparam int MAX_OCC    = (1 << OCC_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [1:0] acc_outcome = 2'd0;
  logic [SIZE_W-1:0] acc_bytes = '0;
  logic acc_wb = 1'b0;
  logic fill_strobe = 1'b0;
  logic data_port_free, fill_port_free;
  logic [STAT_W-1:0] cycles_seen, data_busy_cycles, fill_busy_cycles;

  always #4 clk = ~clk;

  port_occupancy_tracker #(
    .LINE_BYTES(LINE_BYTES), .PORT_BYTES(PORT_BYTES),
    .OCC_W(OCC_W), .STAT_W(STAT_W)
  ) i_port_occupancy_tracker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_outcome(acc_outcome),
    .acc_bytes(acc_bytes), .acc_wb(acc_wb), .fill_strobe(fill_strobe),
    .data_port_free(data_port_free), .fill_port_free(fill_port_free),
    .cycles_seen(cycles_seen), .data_busy_cycles(data_busy_cycles),
    .fill_busy_cycles(fill_busy_cycles)
  );

  int checks = 0;
  int fails  = 0;
  int occ_d = 0, occ_f = 0;
  int m_cyc = 0, m_bd = 0, m_bf = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_charge(input bit v, input int oc, input int b, input bit wb);
    int bb;
    if (!v) return 0;
    if (oc == 0) begin
      bb = (b > LINE_BYTES) ? LINE_BYTES : b;
      return (bb + PORT_BYTES - 1) / PORT_BYTES;
    end
    if (oc == 1 || oc == 2) return wb ? LINE_CYC : 0;
    return 0;
  endfunction

  function automatic int upd(input int o, input int c);
    int s;
    s = o + c;
    if (s == 0) return 0;
    s = s - 1;
    return (s > MAX_OCC) ? MAX_OCC : s;
  endfunction

  // Called at a negedge; drives, lets one edge pass, checks at the next negedge.
  task automatic step(input bit v, input int oc, input int b, input bit wb,
                      input bit f, input string tag);
    acc_valid = v; acc_outcome = 2'(oc); acc_bytes = SIZE_W'(b);
    acc_wb = wb; fill_strobe = f;
    @(posedge clk);
    m_cyc++;
    if (occ_d != 0) m_bd++;
    if (occ_f != 0) m_bf++;
    occ_d = upd(occ_d, exp_charge(v, oc, b, wb));
    occ_f = upd(occ_f, f ? LINE_CYC : 0);
    @(negedge clk);
    chk({tag, " data_free R6"}, int'(data_port_free), int'(occ_d == 0));
    chk({tag, " fill_free R6"}, int'(fill_port_free), int'(occ_f == 0));
    chk("cycles R7", int'(cycles_seen), m_cyc % (1 << STAT_W));
    chk("data_busy R7", int'(data_busy_cycles), m_bd % (1 << STAT_W));
    chk("fill_busy R7", int'(fill_busy_cycles), m_bf % (1 << STAT_W));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, tag);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset data_free R10", int'(data_port_free), 1);
    chk("reset fill_free R10", int'(fill_port_free), 1);
    chk("reset cycles R10", int'(cycles_seen), 0);
    chk("reset busy R10", int'(data_busy_cycles + fill_busy_cycles), 0);
    rst = 1'b0;

    // Sweep every outcome, size and writeback flag, draining after each.
    for (int oc = 0; oc < 4; oc++)
      for (int wb = 0; wb < 2; wb++)
        for (int b = 0; b <= 80; b++) begin
          int c;
          string tg;
          c = exp_charge(1'b1, oc, b, wb[0]);
          tg = (oc == 0) ? "hit R1" : (oc == 3) ? "reject R3" : "miss R2";
          step(1'b1, oc, b, wb[0], 1'b0, tg);
          // occupancy c-1 after the edge: free flag low for exactly c-1 checks
          idle(LINE_CYC + 1, {tg, " drain R5"});
        end

    // Fill charges and overlap with accesses
    step(1'b0, 0, 0, 1'b0, 1'b1, "fill R4");
    idle(2, "fill R4");
    step(1'b0, 0, 0, 1'b0, 1'b1, "fill again R5");
    step(1'b1, 2, 0, 1'b1, 1'b1, "fill+miss R5");
    step(1'b1, 0, 33, 1'b0, 1'b0, "hit overlap R5");
    idle(12, "overlap drain R5");

    // Invalid accesses charge nothing
    for (int oc = 0; oc < 4; oc++)
      step(1'b0, oc, 64, 1'b1, 1'b0, "idle access R9");

    // Saturation
    for (int i = 0; i < 25; i++)
      step(1'b1, 0, 64, 1'b0, 1'b1, "saturate R8");
    chk("saturated level R8", occ_d, MAX_OCC);
    idle(MAX_OCC + 3, "saturate drain R8");

    summary();
    $finish;
  end
endmodule